// File: doc/BRIEF.md
# Processor-to-Memory Crossbar Switch

This block joins a set of requesting processor ports to a set of memory module ports through a full grid of crosspoints, one for each processor and module pair. Each processor drives a request with an address, a write/read flag and write data. The most significant address bits choose the target module, and the remaining bits travel on to that module as its local address. Every module column has its own fixed-priority arbiter. Requests aimed at different modules go through in the same cycle. Requests that collide on one module are handled one per cycle, with the lowest-numbered processor first.

A granted request reaches the memory module in the cycle it is granted. Multiplexers steer the winner's address, write data and write flag onto the module port. The memory modules are external synchronous RAMs, so read data appears one cycle later. Each processor has a small return tracker that routes that data from the module it last read back to itself. The tracker has two states. RS_IDLE is the state after reset and when no read is outstanding. RS_WAIT is held for the cycle after a granted read. IDLE→WAIT and WAIT→WAIT are taken on a granted read. WAIT→IDLE and IDLE→IDLE are taken otherwise. A processor that is not granted sees ready low and must hold its request unchanged until ready rises.

Top module: `xbar_pm`

## Requirements
- R1: A processor's target module is address bits [AW-1:AW-2] (module index 0..3). The granted module port receives the lower AW-2 address bits unchanged on m_addr.
- R2: Per module, at most one processor is granted in a cycle. Among the processors requesting that module, the one with the lowest index wins (processor 0 highest, processor 3 lowest). m_en of a module is high exactly when one of its requesters is granted.
- R3: p_ready of a processor is high in a cycle only if p_req is high and that processor won its target module in that cycle. A requester that loses sees p_ready low.
- R4: Requests to distinct modules are all granted in the same cycle. Four processors aimed at four different modules all see p_ready high together.
- R5: For a granted write (p_we=1), the module port shows m_we=1 and the processor's p_wdata on m_wdata. For a granted read, m_we=0. m_we is never high without m_en.
- R6: After a granted read (p_we=0), p_rvalid of that processor is high in the next cycle, and p_rdata carries the m_rdata of the module that was read. p_rvalid is low in all other cycles.
- R7: While reset is asserted and right after it, with no requests, p_ready, p_rvalid, m_en and m_we are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req | input | NP | Request valid per processor |
| p_we | input | NP | 1 = write, 0 = read, per processor |
| p_addr | input | NP*AW | Processor addresses, processor p at [p*AW +: AW] |
| p_wdata | input | NP*DW | Processor write data, processor p at [p*DW +: DW] |
| p_ready | output | NP | Request granted this cycle |
| p_rvalid | output | NP | Read data valid (one cycle after a granted read) |
| p_rdata | output | NP*DW | Returned read data per processor |
| m_en | output | NM | Module access enable |
| m_we | output | NM | Module write enable |
| m_addr | output | NM*(AW-2) | Module local address |
| m_wdata | output | NM*DW | Module write data |
| m_rdata | input | NM*DW | Module read data, valid one cycle after m_en with m_we=0 |

## Verification
The bench first sends all four processors at one module. A reversed or broken priority chain would then grant the wrong processor or grant two at once, and the arbitration would not drain in the order 0, 1, 2, 3. It then aims every processor at a different module at the same time. A design that shares one arbiter across modules would stall three of them. The random phase mixes reads and writes into a small address window so that reads often follow writes to the same word. A return path that latched the wrong module index, or released data in the wrong cycle, would hand back stale or foreign data. The reference model tracks the memory contents on its own, so such errors show up as mismatches on p_rdata.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_WAIT = 1'b1
    } ret_state_e;
endpackage

// File: rtl/xbar_arb.sv
// Fixed-priority grant for one module column: lowest index wins.
module xbar_arb #(
    parameter int NP = 4,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt,
    output logic [PW-1:0] idx
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int p = NP - 1; p >= 0; p--) begin
            if (req[p]) begin
                gnt    = '0;
                gnt[p] = 1'b1;
                idx    = PW'(p);
            end
        end
    end
endmodule

// File: rtl/xbar_ret.sv
// Per-processor read return tracker.
module xbar_ret
    import xbar_pkg::*;
#(
    parameter int NM = 4,
    parameter int DW = 16,
    localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic [MW-1:0]  mod,
    input  logic [NM*DW-1:0] m_rdata,
    output logic           rvalid,
    output logic [DW-1:0]  rdata
);
    ret_state_e state_q, state_d;
    logic [MW-1:0] mod_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = fire ? RS_WAIT : RS_IDLE;
            RS_WAIT: state_d = fire ? RS_WAIT : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            mod_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire) mod_q <= mod;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            RS_IDLE: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
            RS_WAIT: begin
                rvalid = 1'b1;
                rdata  = m_rdata[int'(mod_q)*DW +: DW];
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end
endmodule

// File: rtl/xbar_pm.sv
module xbar_pm #(
    parameter int NP = 4,
    parameter int NM = 4,
    parameter int AW = 10,
    parameter int DW = 16,
    localparam int MW  = (NM > 1) ? $clog2(NM) : 1,
    localparam int PW  = (NP > 1) ? $clog2(NP) : 1,
    localparam int LAW = AW - MW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     p_req,
    input  logic [NP-1:0]     p_we,
    input  logic [NP*AW-1:0]  p_addr,
    input  logic [NP*DW-1:0]  p_wdata,
    output logic [NP-1:0]     p_ready,
    output logic [NP-1:0]     p_rvalid,
    output logic [NP*DW-1:0]  p_rdata,
    output logic [NM-1:0]     m_en,
    output logic [NM-1:0]     m_we,
    output logic [NM*LAW-1:0] m_addr,
    output logic [NM*DW-1:0]  m_wdata,
    input  logic [NM*DW-1:0]  m_rdata
);
    logic [MW-1:0] tgt [NP];
    logic [NP-1:0] col_req [NM];
    logic [NP-1:0] col_gnt [NM];
    logic [PW-1:0] col_idx [NM];

    // Crosspoint address decode: each processor's top bits name its module.
    for (genvar p = 0; p < NP; p++) begin : g_dec
        assign tgt[p] = p_addr[p*AW + AW - 1 -: MW];
    end

    // One independent arbiter and output multiplexer per module column.
    for (genvar m = 0; m < NM; m++) begin : g_col
        for (genvar p = 0; p < NP; p++) begin : g_xp
            assign col_req[m][p] = p_req[p] && (tgt[p] == MW'(m));
        end

        xbar_arb #(.NP(NP)) u_arb (
            .req (col_req[m]),
            .gnt (col_gnt[m]),
            .idx (col_idx[m])
        );

        assign m_en[m]                   = |col_gnt[m];
        assign m_we[m]                   = m_en[m] && p_we[col_idx[m]];
        assign m_addr[m*LAW +: LAW]      = p_addr[int'(col_idx[m])*AW +: LAW];
        assign m_wdata[m*DW +: DW]       = p_wdata[int'(col_idx[m])*DW +: DW];
    end

    always_comb begin
        p_ready = '0;
        for (int m = 0; m < NM; m++) begin
            p_ready = p_ready | col_gnt[m];
        end
    end

    // Read return path per processor.
    for (genvar p = 0; p < NP; p++) begin : g_ret
        xbar_ret #(.NM(NM), .DW(DW)) u_ret (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (p_ready[p] && !p_we[p]),
            .mod     (tgt[p]),
            .m_rdata (m_rdata),
            .rvalid  (p_rvalid[p]),
            .rdata   (p_rdata[p*DW +: DW])
        );
    end
endmodule

// File: rtl/xbar_pm_chk.sv
module xbar_pm_chk #(
    parameter int NP = 4,
    parameter int NM = 4,
    parameter int AW = 10,
    parameter int DW = 16,
    localparam int MW  = (NM > 1) ? $clog2(NM) : 1,
    localparam int LAW = AW - MW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NP-1:0]     p_req,
    input logic [NP-1:0]     p_we,
    input logic [NP*AW-1:0]  p_addr,
    input logic [NP*DW-1:0]  p_wdata,
    input logic [NP-1:0]     p_ready,
    input logic [NP-1:0]     p_rvalid,
    input logic [NP*DW-1:0]  p_rdata,
    input logic [NM-1:0]     m_en,
    input logic [NM-1:0]     m_we,
    input logic [NM*LAW-1:0] m_addr,
    input logic [NM*DW-1:0]  m_wdata,
    input logic [NM*DW-1:0]  m_rdata
);
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ready & ~p_req) == '0); // R3

    AST_GRANTS_MATCH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(p_ready) == $countones(m_en)); // R2

    AST_TOP_PRIORITY_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        p_req[0] |-> p_ready[0]); // R2

    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we & ~m_en) == '0); // R5

    for (genvar p = 0; p < NP; p++) begin : g_p
        AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
            (p_ready[p] && !p_we[p]) |=> p_rvalid[p]); // R6

        AST_RVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (p_rvalid[p] && !$past(!rst_n)) |-> $past(p_ready[p] && !p_we[p])); // R6
    end
endmodule

bind xbar_pm xbar_pm_chk #(.NP(NP), .NM(NM), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_ready(p_ready), .p_rvalid(p_rvalid), .p_rdata(p_rdata),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
);

// File: tb/tb_xbar_pm.sv
module tb_xbar_pm;
    localparam int NP = 4, NM = 4, AW = 10, DW = 16;
    localparam int LAW = AW - 2, DEPTH = 1 << LAW;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0]     p_req = '0, p_we = '0;
    logic [NP*AW-1:0]  p_addr = '0;
    logic [NP*DW-1:0]  p_wdata = '0;
    logic [NP-1:0]     p_ready, p_rvalid;
    logic [NP*DW-1:0]  p_rdata;
    logic [NM-1:0]     m_en, m_we;
    logic [NM*LAW-1:0] m_addr;
    logic [NM*DW-1:0]  m_wdata;
    logic [NM*DW-1:0]  m_rdata = '0;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] ram    [NM][DEPTH];
    logic [DW-1:0] shadow [NM][DEPTH];
    logic [NP-1:0] last_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_pm #(.NP(NP), .NM(NM), .AW(AW), .DW(DW)) dut (.*);

    // Memory modules: synchronous RAMs.
    always @(posedge clk) begin
        for (int m = 0; m < NM; m++) begin
            if (m_en[m]) begin
                if (m_we[m]) ram[m][m_addr[m*LAW +: LAW]] <= m_wdata[m*DW +: DW];
                else m_rdata[m*DW +: DW] <= ram[m][m_addr[m*LAW +: LAW]];
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_req(input int p, input bit v, input bit we, input int mod,
                           input int la, input logic [DW-1:0] wd);
        p_req[p] = v;
        p_we[p]  = we;
        p_addr[p*AW +: AW] = {mod[1:0], la[LAW-1:0]};
        p_wdata[p*DW +: DW] = wd;
    endtask

    // One cycle: model predicts, compare combinational outputs, advance, compare return.
    task automatic step();
        bit taken [NM];
        logic [NP-1:0] er;
        logic [NP-1:0] nv;
        logic [DW-1:0] nd [NP];
        logic [NM-1:0] een, ewe;
        int who [NM];
        #1;
        er = '0; nv = '0; een = '0; ewe = '0;
        for (int m = 0; m < NM; m++) begin taken[m] = 0; who[m] = 0; end
        for (int p = 0; p < NP; p++) begin
            nd[p] = '0;
            if (p_req[p]) begin
                int m = int'(p_addr[p*AW + AW - 1 -: 2]);
                if (!taken[m]) begin
                    taken[m] = 1; who[m] = p; er[p] = 1'b1;
                    een[m] = 1'b1; ewe[m] = p_we[p];
                end
            end
        end
        chk("R3 p_ready", 64'(p_ready), 64'(er));
        chk("R2 m_en", 64'(m_en), 64'(een));
        chk("R5 m_we", 64'(m_we), 64'(ewe));
        for (int m = 0; m < NM; m++) begin
            if (een[m]) begin
                int p = who[m];
                logic [LAW-1:0] la = p_addr[p*AW +: LAW];
                chk("R1 m_addr", 64'(m_addr[m*LAW +: LAW]), 64'(la));
                if (ewe[m]) chk("R5 m_wdata", 64'(m_wdata[m*DW +: DW]), 64'(p_wdata[p*DW +: DW]));
                if (!ewe[m]) begin nv[p] = 1'b1; nd[p] = shadow[m][la]; end
                else shadow[m][la] = p_wdata[p*DW +: DW];
            end
        end
        last_ready = p_ready;
        @(posedge clk); @(negedge clk);
        chk("R6 p_rvalid", 64'(p_rvalid), 64'(nv));
        for (int p = 0; p < NP; p++)
            if (nv[p]) chk("R6 p_rdata", 64'(p_rdata[p*DW +: DW]), 64'(nd[p]));
        for (int p = 0; p < NP; p++) if (er[p]) p_req[p] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < NM; m++)
            for (int a = 0; a < DEPTH; a++) begin
                ram[m][a]    = DW'(m * 1000 + a);
                shadow[m][a] = DW'(m * 1000 + a);
            end
        repeat (3) @(negedge clk);
        chk("R7 reset p_ready", 64'(p_ready), 0);
        chk("R7 reset p_rvalid", 64'(p_rvalid), 0);
        chk("R7 reset m_en", 64'(m_en), 0);
        chk("R7 reset m_we", 64'(m_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        step();
        chk("R7 idle m_en", 64'(m_en), 0);

        // All four read module 2: drained in priority order 0,1,2,3.
        for (int p = 0; p < NP; p++) set_req(p, 1, 0, 2, 5 + p, '0);
        for (int k = 0; k < NP; k++) begin
            step();
            chk("R2 priority order", 64'(last_ready), 64'(1 << k));
        end

        // Each processor to its own module: all granted at once.
        for (int p = 0; p < NP; p++) set_req(p, 1, 1, 3 - p, 7, DW'(16'hA000 + p));
        step();
        chk("R4 concurrent grants", 64'(last_ready), 64'hF);
        for (int p = 0; p < NP; p++) set_req(p, 1, 0, 3 - p, 7, '0);
        step();
        chk("R4 concurrent reads", 64'(last_ready), 64'hF);

        // Random traffic, requests held until granted.
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < NP; p++)
                if (!p_req[p] && ($urandom % 10) < 7)
                    set_req(p, 1, ($urandom % 2) == 1, int'($urandom % NM),
                            int'($urandom % 8), DW'($urandom));
            step();
        end
        p_req = '0;
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule